// File: doc/BRIEF.md
# Decimal Accumulator Mailbox Processor

This block is a small accumulator machine. Every instruction is a word with a value from 000 to 999. The hundreds digit selects the operation, and the two lower digits name one of 100 mailboxes in an internal word memory. A single accumulator is both the source and the destination of every operation. The second operand, when there is one, comes from the addressed mailbox. Arithmetic is taken modulo 1000. A separate negative flag records whether the last subtraction went below zero, and the two conditional branches test that flag.

Memory is filled through a load port while the machine is stopped. A one-cycle start pulse then launches execution at mailbox 0, with the accumulator and the flag cleared. Each instruction uses a fetch cycle and then an execute cycle.

Values enter through an input port with a valid/ready handshake, and the machine waits on it for as long as needed. Results leave through an output port as a one-cycle strobe that carries the accumulator value. The machine stops on a halt word. It also stops on any word it does not recognise, and in that case it raises a fault flag.

Top module: `mailbox_cpu`

## Requirements
- R1: After reset the machine is stopped but not halted: `halted`, `fault`, `out_valid` and `in_ready` are all low.
- R2: While the machine is idle or halted, `load_en` writes `load_word` into mailbox `load_addr`. A `start` pulse begins execution at mailbox 0 with the accumulator at 0, the negative flag clear and `fault` cleared.
- R3: A word is decoded as its hundreds digit (the operation) and its value modulo 100 (the mailbox). Operation 5 loads the accumulator from the mailbox and clears the negative flag. Operation 3 stores the accumulator into the mailbox.
- R4: Operation 1 adds the mailbox value to the accumulator modulo 1000 and clears the negative flag.
- R5: Operation 2 subtracts the mailbox value from the accumulator modulo 1000. The negative flag is set when the true difference is below zero and cleared otherwise.
- R6: Operation 6 always jumps to the mailbox address. Operation 7 jumps only when the accumulator is 0 and the negative flag is clear. Operation 8 jumps only when the negative flag is clear, so a zero accumulator counts as positive.
- R7: Word 901 raises `in_ready` and holds the machine until `in_valid` is high. On that edge, `in_data` (below 1000) becomes the accumulator and the negative flag clears.
- R8: Word 902 drives `out_valid` high for exactly one cycle, with `out_data` equal to the accumulator.
- R9: Word 000 halts the machine: `halted` goes high, `fault` stays low, and both hold until the next `start`.
- R10: Any other word halts the machine with `fault` high. This covers operation 4, operation 0 with a nonzero mailbox, operation 9 with a mailbox other than 1 or 2, and values of 1000 and above.
- R11: The program counter advances from mailbox 99 to mailbox 0.
- R12: Every instruction takes one fetch cycle and one execute cycle, apart from the wait on input. A jump to an output word therefore strobes `out_valid` four cycles after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write enable for the load port (honoured only when stopped) |
| load_addr | input | 7 | Mailbox written by the load port |
| load_word | input | 10 | Word written by the load port |
| start | input | 1 | Begin execution at mailbox 0 |
| in_valid | input | 1 | Input value available |
| in_data | input | 10 | Input value |
| in_ready | output | 1 | Machine is waiting on an input word |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 10 | Accumulator value sent out |
| halted | output | 1 | Machine has stopped on a halt or bad word |
| fault | output | 1 | Stop was caused by an unrecognised word |

## Verification
Several rules are checked by assertions on every cycle:
- the program counter stays within the mailbox range;
- add and subtract results stay below 1000;
- fetch is always followed by execute;
- the output strobe never lasts two cycles;
- a stall on input leaves the accumulator unchanged;
- a fault always comes with a halt;
- a halted machine stays halted until started.

Other behaviours can only be shown by the bench's programs, because they depend on decoded values:
- that the decimal digits select the right operation;
- that subtraction wraps to 999 and sets the flag;
- that each branch is taken or skipped exactly as the flag and accumulator require;
- that execution wraps from mailbox 99 to mailbox 0;
- that each malformed word ends in a fault.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W   = 10;
    localparam int ADDR_W   = 7;
    localparam int MBOXES   = 100;
    localparam int WORD_MOD = 1000;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WORD_W:0]   wide_t;
    typedef logic [ADDR_W-1:0] mbox_t;

    typedef enum logic [3:0] {
        OP_HLT, OP_ADD, OP_SUB, OP_STO, OP_LDA,
        OP_BR,  OP_BRZ, OP_BRP, OP_IN,  OP_OUT, OP_BAD
    } op_e;

    typedef struct packed {
        op_e   op;
        mbox_t addr;
    } instr_t;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_STOP} state_e;

    function automatic mbox_t next_pc(input mbox_t pc);
        return (pc == mbox_t'(MBOXES - 1)) ? '0 : pc + mbox_t'(1);
    endfunction

endpackage

// File: rtl/mbx_mem.sv
module mbx_mem #(
    parameter int DEPTH = 100,
    parameter int W     = 10,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we && waddr <= LAST) cells[waddr] <= wdata;
    end

    assign rdata = (raddr <= LAST) ? cells[raddr] : '0;
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  word_t  word,
    output instr_t ins
);
    logic [3:0] hund;
    mbox_t      low;

    always_comb begin
        hund     = 4'(word / 10'd100);
        low      = 7'(word % 10'd100);
        ins.addr = low;
        case (hund)
            4'd0:    ins.op = (low == '0) ? OP_HLT : OP_BAD;
            4'd1:    ins.op = OP_ADD;
            4'd2:    ins.op = OP_SUB;
            4'd3:    ins.op = OP_STO;
            4'd5:    ins.op = OP_LDA;
            4'd6:    ins.op = OP_BR;
            4'd7:    ins.op = OP_BRZ;
            4'd8:    ins.op = OP_BRP;
            4'd9:    ins.op = (low == 7'd1) ? OP_IN :
                              (low == 7'd2) ? OP_OUT : OP_BAD;
            default: ins.op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/mbx_alu.sv
module mbx_alu
    import mbx_pkg::*;
(
    input  word_t acc,
    input  word_t opnd,
    input  logic  sub,
    output word_t res,
    output logic  under
);
    wide_t sum;

    always_comb begin
        sum   = {1'b0, acc} + {1'b0, opnd};
        under = 1'b0;
        if (!sub) begin
            res = (sum >= wide_t'(WORD_MOD)) ? word_t'(sum - wide_t'(WORD_MOD))
                                             : word_t'(sum);
        end else begin
            under = acc < opnd;
            res   = under ? word_t'(acc + word_t'(WORD_MOD) - opnd)
                          : word_t'(acc - opnd);
        end
    end
endmodule

// File: rtl/mailbox_cpu.sv
module mailbox_cpu
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_word,
    input  logic              start,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              halted,
    output logic              fault
);
    state_e state;
    mbox_t  pc;
    word_t  acc;
    word_t  ir;
    logic   neg;
    instr_t ins;

    logic   mem_we;
    mbox_t  mem_waddr, mem_raddr;
    word_t  mem_wdata, mem_rdata;
    word_t  alu_res;
    logic   alu_under;
    logic   stopped;

    assign stopped = (state == ST_IDLE) || (state == ST_STOP);

    mbx_decode u_dec (.word(ir), .ins(ins));

    mbx_alu u_alu (
        .acc(acc), .opnd(mem_rdata), .sub(ins.op == OP_SUB),
        .res(alu_res), .under(alu_under)
    );

    always_comb begin
        if (stopped) begin
            mem_we    = load_en;
            mem_waddr = load_addr;
            mem_wdata = load_word;
        end else begin
            mem_we    = (state == ST_EXEC) && (ins.op == OP_STO);
            mem_waddr = ins.addr;
            mem_wdata = acc;
        end
        mem_raddr = (state == ST_FETCH) ? pc : ins.addr;
    end

    mbx_mem #(.DEPTH(MBOXES), .W(WORD_W), .AW(ADDR_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pc        <= '0;
            acc       <= '0;
            ir        <= '0;
            neg       <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            fault     <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            case (state)
                ST_IDLE, ST_STOP: begin
                    if (start) begin
                        state <= ST_FETCH;
                        pc    <= '0;
                        acc   <= '0;
                        neg   <= 1'b0;
                        fault <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    ir    <= mem_rdata;
                    pc    <= next_pc(pc);
                    state <= ST_EXEC;
                end
                default: begin
                    state <= ST_FETCH;
                    case (ins.op)
                        OP_LDA: begin acc <= mem_rdata; neg <= 1'b0; end
                        OP_ADD: begin acc <= alu_res;   neg <= 1'b0; end
                        OP_SUB: begin acc <= alu_res;   neg <= alu_under; end
                        OP_IN: begin
                            if (in_valid) begin
                                acc <= in_data;
                                neg <= 1'b0;
                            end else begin
                                state <= ST_EXEC;
                            end
                        end
                        OP_OUT: begin
                            out_valid <= 1'b1;
                            out_data  <= acc;
                        end
                        OP_BR:  pc <= ins.addr;
                        OP_BRZ: if (acc == '0 && !neg) pc <= ins.addr;
                        OP_BRP: if (!neg) pc <= ins.addr;
                        OP_HLT: state <= ST_STOP;
                        OP_BAD: begin state <= ST_STOP; fault <= 1'b1; end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    assign halted   = (state == ST_STOP);
    assign in_ready = (state == ST_EXEC) && (ins.op == OP_IN);

    // R11: program counter never leaves the mailbox range
    p_pc_range_r11: assert property (@(posedge clk) disable iff (rst)
        pc <= mbox_t'(MBOXES - 1));

    // R4 / R5: arithmetic lands inside the decimal word range
    p_mod_range_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && (ins.op == OP_ADD || ins.op == OP_SUB))
        |=> acc < word_t'(WORD_MOD));

    // R4: an add leaves the negative flag clear
    p_add_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && ins.op == OP_ADD) |=> !neg);

    // R12: fetch is always followed by execute
    p_two_cycle_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (state == ST_EXEC));

    // R8: output strobe lasts one cycle
    p_out_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7: waiting on input keeps the accumulator and the request
    p_ready_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (in_ready && $stable(acc)));

    // R10: a fault only appears together with a halt
    p_fault_halt_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> halted);

    // R9: a halted machine stays halted until started
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (halted && !start) |=> (halted && $stable(fault)));
endmodule

// File: tb/mailbox_cpu_bench.sv
module mailbox_cpu_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       load_en;
    logic [6:0] load_addr;
    logic [9:0] load_word;
    logic       start;
    logic       in_valid;
    logic [9:0] in_data;
    logic       in_ready;
    logic       out_valid;
    logic [9:0] out_data;
    logic       halted;
    logic       fault;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    mailbox_cpu u_mailbox_cpu (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_word(load_word), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .halted(halted), .fault(fault)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_out(input int v);
        exp_q.push_back(v);
    endtask

    // scoreboard monitor (R8)
    always @(negedge clk) begin : mon
        int e;
        if (!rst && out_valid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected output: actual %0d expected none", out_data);
            end else begin
                e = exp_q.pop_front();
                if (out_data !== 10'(e)) begin
                    n_bad++;
                    $display("FAIL R8 output value: actual %0d expected %0d", out_data, e);
                end
            end
        end
    end

    task automatic load(input int a, input int w);
        @(negedge clk);
        load_en = 1'b1; load_addr = 7'(a); load_word = 10'(w);
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 100; i++) load(i, 0);
    endtask

    task automatic run();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic feed(input int v);
        in_valid = 1'b1; in_data = 10'(v);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_halt(input string req);
        int n = 0;
        while (!halted && n < 3000) begin @(negedge clk); n++; end
        check(halted, req, "halted reached", halted, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; load_en = 1'b0; load_addr = '0; load_word = '0;
        start = 1'b0; in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!halted && !fault && !out_valid && !in_ready, "R1", "outputs idle",
              {halted, fault, out_valid, in_ready}, 0);

        // Program A: countdown; R2 R3 R5 R6 R7 R9
        clear_mem();
        load(0, 901); load(1, 390); load(2, 590); load(3, 902);
        load(4, 291); load(5, 390); load(6, 802); load(7, 902);
        load(8, 0);   load(91, 1);
        expect_out(3); expect_out(2); expect_out(1); expect_out(0); expect_out(999);
        run();
        repeat (6) @(negedge clk);
        check(in_ready, "R7", "in_ready while stalled", in_ready, 1);
        check(!halted, "R7", "not halted while stalled", halted, 0);
        feed(3);
        wait_halt("R9");
        check(!fault, "R9", "halt word leaves fault low", fault, 0);
        repeat (5) @(negedge clk);
        check(halted && !fault, "R9", "halt holds", halted, 1);
        check(exp_q.size() == 0, "R5", "all countdown outputs seen", exp_q.size(), 0);

        // Program B: add wrap, branches, bad word 4XX; R4 R6 R10
        clear_mem();
        load(0, 901); load(1, 150); load(2, 902); load(3, 251);
        load(4, 707); load(5, 902); load(6, 0);   load(7, 902);
        load(8, 252); load(9, 712); load(10, 902); load(11, 613);
        load(12, 902); load(13, 553); load(14, 815); load(15, 902);
        load(16, 400);
        load(50, 500); load(51, 100); load(52, 5); load(53, 7);
        expect_out(100); expect_out(0); expect_out(995); expect_out(7);
        run();
        feed(600);
        wait_halt("R10");
        check(fault, "R10", "fault on 4XX", fault, 1);
        check(exp_q.size() == 0, "R6", "branch outputs seen", exp_q.size(), 0);

        // Program C: jump, wrap and self-modify; R2 R11 R12
        clear_mem();
        load(0, 698); load(98, 902); load(99, 300);
        expect_out(0);
        run();
        repeat (3) @(negedge clk);
        check(!out_valid, "R12", "no strobe before cycle 4", out_valid, 0);
        @(negedge clk);
        check(out_valid, "R12", "strobe on cycle 4", out_valid, 1);
        check(out_data == 0, "R2", "start clears accumulator", out_data, 0);
        wait_halt("R11");
        check(!fault, "R11", "wrap reached stored halt", fault, 0);
        check(exp_q.size() == 0, "R11", "wrap output seen", exp_q.size(), 0);

        // Program D: 0XX nonzero; R10
        clear_mem();
        load(0, 50);
        run();
        wait_halt("R10");
        check(fault, "R10", "fault on 050", fault, 1);

        // Program E: 9XX other than 901/902; R10, then restart clears fault (R2)
        load(0, 905);
        run();
        @(negedge clk);
        check(!fault && !halted, "R2", "start clears fault", fault, 0);
        wait_halt("R10");
        check(fault, "R10", "fault on 905", fault, 1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8", "no pending outputs", exp_q.size(), 0);
        summary();
    end
endmodule